// File: doc/BRIEF.md
# Compare and Branch Decision Unit

This block sits between the register file and the program counter of a small 8-bit processor. On a compare strobe it subtracts a second operand from a register operand without writing the difference back. The second operand is either another register or one of a few built-in constants. The block keeps the resulting zero and carry flags. A flag-setting ALU operation, such as an add, may also load the two flags. Because of this, an unsigned add that overflows leaves the carry set, and a following "less" jump is taken.

On a jump request the unit combines the stored flags with a condition code to decide whether the jump is taken. It then produces the next program counter. A taken jump goes either to an absolute 16-bit target or to a signed 8-bit offset from the address of the next instruction. A jump that is not taken, and any cycle with no jump request, falls through to the current PC plus the instruction length.

Top module: `branch_decider`

## Requirements
- R1: After reset both stored flags (`flag_z`, `flag_c`) read 0.
- R2: When `cmp_en` is high and `use_const` is low, the flags after the next clock edge are Z = (`op_a` == `op_b`) and C = (`op_a` < `op_b` unsigned).
- R3: When `cmp_en` and `use_const` are both high, `op_b` is ignored and the constant is picked by `const_sel`: 0 gives 0x00, 1 gives 0x01, 2 gives 0xFF (minus one), and 3 gives 0xFF (255).
- R4: When `alu_upd` is high and `cmp_en` is low, the flags take `alu_z` and `alu_c` at the next edge. If both strobes are high, the compare wins.
- R5: With both `cmp_en` and `alu_upd` low, the flags keep their value.
- R6: With `jmp_en` high, `taken` follows `jmp_cond` as a function of the stored flags: 0 = always, 1 = Z, 2 = !Z, 3 = C, 4 = C|Z, 5 = !C&!Z, 6 = !C, 7 = never.
- R7: A taken jump with `jmp_rel` low gives `next_pc` = `target`.
- R8: A taken jump with `jmp_rel` high gives `next_pc` = `pc` + `ins_len` + sign-extended `target[7:0]`, modulo 2^16.
- R9: With `jmp_en` low, `taken` is 0. When no jump is taken, `next_pc` = `pc` + `ins_len`.
- R10: `taken` depends on the flags stored before the current edge. A compare in the same cycle does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_en | input | 1 | Compare strobe |
| use_const | input | 1 | Compare against a constant instead of `op_b` |
| const_sel | input | 2 | Constant select code |
| op_a | input | 8 | Left operand register |
| op_b | input | 8 | Right operand register |
| alu_upd | input | 1 | ALU flag load strobe |
| alu_z | input | 1 | Zero flag from ALU |
| alu_c | input | 1 | Carry flag from ALU |
| jmp_en | input | 1 | Jump request |
| jmp_cond | input | 3 | Condition code |
| jmp_rel | input | 1 | Relative jump mode |
| pc | input | 16 | Current program counter |
| ins_len | input | 2 | Current instruction length in bytes |
| target | input | 16 | Absolute target, or offset in low byte |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| taken | output | 1 | Jump taken |
| next_pc | output | 16 | Next program counter |

## Verification
The assertions assume the inputs hold known values whenever the unit is out of reset. They make no assumption about how the strobes are combined. In particular, compare and ALU load may both be high in the same cycle, and a jump may share a cycle with either. The stimulus draws every field independently from a seeded generator, so all of these overlaps occur. Directed cases cover equal and wrapped operands, all four constant codes, add overflow followed by a "less" jump, and relative offsets that wrap around the PC space.

// File: rtl/branch_decider.sv
module branch_decider #(
  parameter int DW  = 8,
  parameter int PCW = 16,
  parameter int LW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmp_en,
  input  logic           use_const,
  input  logic [1:0]     const_sel,
  input  logic [DW-1:0]  op_a,
  input  logic [DW-1:0]  op_b,
  input  logic           alu_upd,
  input  logic           alu_z,
  input  logic           alu_c,
  input  logic           jmp_en,
  input  logic [2:0]     jmp_cond,
  input  logic           jmp_rel,
  input  logic [PCW-1:0] pc,
  input  logic [LW-1:0]  ins_len,
  input  logic [PCW-1:0] target,
  output logic           flag_z,
  output logic           flag_c,
  output logic           taken,
  output logic [PCW-1:0] next_pc
);
  localparam int XW = PCW - DW;

  logic [DW-1:0] rhs;
  logic [DW:0]   diff;
  logic          cond_ok;
  logic [PCW-1:0] fall_pc, rel_pc;

  always_comb begin
    case (const_sel)
      2'd0:    rhs = '0;
      2'd1:    rhs = DW'(1);
      default: rhs = '1;
    endcase
    if (!use_const) rhs = op_b;
  end

  assign diff = {1'b0, op_a} - {1'b0, rhs};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else if (cmp_en) begin
      flag_z <= (diff[DW-1:0] == '0);
      flag_c <= diff[DW];
    end else if (alu_upd) begin
      flag_z <= alu_z;
      flag_c <= alu_c;
    end
  end

  always_comb begin
    case (jmp_cond)
      3'd0: cond_ok = 1'b1;
      3'd1: cond_ok = flag_z;
      3'd2: cond_ok = !flag_z;
      3'd3: cond_ok = flag_c;
      3'd4: cond_ok = flag_c | flag_z;
      3'd5: cond_ok = !flag_c & !flag_z;
      3'd6: cond_ok = !flag_c;
      default: cond_ok = 1'b0;
    endcase
  end

  assign taken   = jmp_en & cond_ok;
  assign fall_pc = pc + PCW'(ins_len);
  assign rel_pc  = fall_pc + {{XW{target[DW-1]}}, target[DW-1:0]};
  assign next_pc = !taken ? fall_pc : (jmp_rel ? rel_pc : target);
endmodule

// File: rtl/branch_decider_chk.sv
module branch_decider_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmp_en,
  input logic        use_const,
  input logic [7:0]  op_a,
  input logic [7:0]  op_b,
  input logic        alu_upd,
  input logic        alu_z,
  input logic        alu_c,
  input logic        jmp_en,
  input logic [2:0]  jmp_cond,
  input logic [15:0] pc,
  input logic [1:0]  ins_len,
  input logic        flag_z,
  input logic        flag_c,
  input logic        taken,
  input logic [15:0] next_pc
);
  p_reg_cmp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && !use_const) |=> (flag_z == ($past(op_a) == $past(op_b))) &&
                               (flag_c == ($past(op_a) < $past(op_b))));
  p_alu_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_upd && !cmp_en) |=> (flag_z == $past(alu_z)) && (flag_c == $past(alu_c)));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en && !alu_upd) |=> $stable({flag_z, flag_c}));
  p_eq_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_en && jmp_cond == 3'd1) |-> taken == flag_z);
  p_lt_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_en && jmp_cond == 3'd3) |-> taken == flag_c);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !jmp_en |-> !taken && next_pc == pc + 16'(ins_len));
endmodule

bind branch_decider branch_decider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .use_const(use_const),
  .op_a(op_a), .op_b(op_b), .alu_upd(alu_upd), .alu_z(alu_z), .alu_c(alu_c),
  .jmp_en(jmp_en), .jmp_cond(jmp_cond), .pc(pc), .ins_len(ins_len),
  .flag_z(flag_z), .flag_c(flag_c), .taken(taken), .next_pc(next_pc)
);

// File: tb/tb_branch_decider.sv
module tb_branch_decider;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp_en = 0, use_const = 0, alu_upd = 0, alu_z = 0, alu_c = 0;
  logic jmp_en = 0, jmp_rel = 0;
  logic [1:0] const_sel = 0, ins_len = 0;
  logic [2:0] jmp_cond = 0;
  logic [7:0] op_a = 0, op_b = 0;
  logic [15:0] pc = 0, target = 0;
  logic flag_z, flag_c, taken;
  logic [15:0] next_pc;
  int total = 0, bad = 0;
  logic mz = 0, mc = 0;

  always #2 clk = ~clk;

  branch_decider dut (.*);

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic cond_f(input logic [2:0] c, input logic z, input logic cy);
    case (c)
      3'd0: return 1'b1;
      3'd1: return z;
      3'd2: return !z;
      3'd3: return cy;
      3'd4: return cy | z;
      3'd5: return !cy & !z;
      3'd6: return !cy;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] const_f(input logic [1:0] s);
    return (s == 2'd0) ? 8'h00 : (s == 2'd1) ? 8'h01 : 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs set after negedge; combinational outputs checked before posedge; flags after.
  task automatic step(input string req);
    logic t;
    logic [7:0] rhs;
    logic [15:0] fall, npc;
    #1;
    t = jmp_en && cond_f(jmp_cond, mz, mc);
    fall = pc + 16'(ins_len);
    npc = !t ? fall : jmp_rel ? fall + {{8{target[7]}}, target[7:0]} : target;
    chk({req, " R6 R10 taken"}, 32'(taken), 32'(t));
    chk({req, " R7 R8 R9 next_pc"}, 32'(next_pc), 32'(npc));
    rhs = use_const ? const_f(const_sel) : op_b;
    if (cmp_en) begin mz = (op_a == rhs); mc = (op_a < rhs); end
    else if (alu_upd) begin mz = alu_z; mc = alu_c; end
    @(negedge clk);
    chk({req, " R2 R3 R4 R5 flags"}, 32'({flag_z, flag_c}), 32'({mz, mc}));
  endtask

  task automatic idle();
    cmp_en = 0; alu_upd = 0; jmp_en = 0; use_const = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    chk("R1 reset flags", 32'({flag_z, flag_c}), 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flags after release", 32'({flag_z, flag_c}), 32'd0);

    idle(); cmp_en = 1; op_a = 8'h42; op_b = 8'h42; step("R2 equal");
    idle(); cmp_en = 1; op_a = 8'h00; op_b = 8'hFF; step("R2 less");
    idle(); cmp_en = 1; op_a = 8'h80; op_b = 8'h7F; step("R2 greater");
    for (int s = 0; s < 4; s++) begin
      idle(); cmp_en = 1; use_const = 1; const_sel = 2'(s); op_a = 8'hFF; op_b = 8'h00;
      step("R3 const vs FF");
      idle(); cmp_en = 1; use_const = 1; const_sel = 2'(s); op_a = 8'h01; op_b = 8'h01;
      step("R3 const vs 01");
    end
    idle(); alu_upd = 1; alu_c = 1; alu_z = 0; step("R4 add overflow");
    idle(); jmp_en = 1; jmp_cond = 3'd3; pc = 16'h0100; ins_len = 2; target = 16'h0000;
    step("R4 R6 less after overflow");
    idle(); cmp_en = 1; alu_upd = 1; alu_z = 0; alu_c = 1; op_a = 5; op_b = 5;
    step("R4 compare wins");
    idle(); op_a = 1; op_b = 9; step("R5 hold");
    idle(); jmp_en = 1; jmp_rel = 1; jmp_cond = 0; pc = 16'hFFFE; ins_len = 3; target = 16'h0005;
    step("R8 wrap forward");
    idle(); jmp_en = 1; jmp_rel = 1; jmp_cond = 0; pc = 16'h0002; ins_len = 1; target = 16'h0080;
    step("R8 wrap back");
    idle(); jmp_en = 1; cmp_en = 1; jmp_cond = 3'd2; op_a = 3; op_b = 4; step("R10 same cycle");

    for (int i = 0; i < 3000; i++) begin
      {cmp_en, use_const, alu_upd, alu_z, alu_c, jmp_en, jmp_rel} = 7'($urandom);
      const_sel = 2'($urandom); ins_len = 2'($urandom); jmp_cond = 3'($urandom);
      op_a = 8'($urandom); op_b = ($urandom % 4 == 0) ? op_a : 8'($urandom);
      pc = 16'($urandom); target = 16'($urandom);
      step("random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule